// File: doc/BRIEF.md
# Ancillary Data FIFO with Word-Level Threshold Interrupt

This block buffers bytes of sliced ancillary data arriving from a video data processor and hands them on to one of two consumers. Bytes enter through a write strobe. They leave either through a host read port or through a pop onto the 8-bit video output bus. A one-bit routing register picks which of the two consumers drains the store. Fill level is judged in 16-bit words (two bytes each) against an 8-bit programmable threshold. This produces a level interrupt for the host.

A strobe on the flush input empties the store in one cycle and clears the overflow flag and both data output registers. The data on the register bus is not used. A two-state sequencer, RUN and FLUSH, carries out the flush. The transition RUN→FLUSH is taken on a flush strobe. The transition FLUSH→RUN is taken when no new strobe arrives. A strobe that arrives while in FLUSH keeps the sequencer in FLUSH. The flush status bit reads 1 only while the sequencer is in FLUSH, so it clears itself.

Top module: `anc_data_fifo`

## Requirements
- R1: After reset the threshold is 0x80, the routing select is 0 (video bus), the store is empty, and host_data, vid_data, vid_valid, thresh_irq, overflow and flush_busy are all 0.
- R2: Bytes leave in the order they were written. The store holds up to 512 bytes.
- R3: A write while 512 bytes are stored is dropped and sets overflow. Overflow stays set until a flush, whatever reads follow.
- R4: thresh_irq is high exactly when floor(stored bytes / 2) is strictly greater than the threshold. It follows the fill count in the same cycle the count register changes, so it falls as soon as occupancy drops to or below the threshold.
- R5: A threshold write (thresh_we with thresh_val) takes effect at the next clock edge and changes the interrupt comparison from then on.
- R6: The cycle after a flush_we strobe, flush_busy is 1. In that cycle the store, overflow, host_data, vid_data and vid_valid are cleared, and any push or pop in the same cycle is ignored. flush_busy returns to 0 on the following cycle unless another strobe arrived.
- R7: With routing select 0, a vid_pop on a non-empty store puts the head byte on vid_data with vid_valid high for one cycle, one cycle later. host_rd is ignored and host_data holds its value.
- R8: With routing select 1, a host_rd on a non-empty store puts the head byte on host_data one cycle later. vid_pop is ignored and vid_valid stays 0.
- R9: A host read on an empty store (routing 1) returns 0x00 and moves nothing. A vid_pop on an empty store leaves vid_valid low and vid_data unchanged.
- R10: A push and an accepted pop in the same cycle both take effect, and the fill count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_byte | input | 8 | Byte to store |
| host_rd | input | 1 | Host read strobe |
| vid_pop | input | 1 | Video-bus pop strobe |
| thresh_we | input | 1 | Threshold register write |
| thresh_val | input | 8 | New threshold in words |
| flush_we | input | 1 | Flush register write (data value irrelevant) |
| route_we | input | 1 | Routing register write |
| route_sel | input | 1 | 0 = video bus drains, 1 = host drains |
| host_data | output | 8 | Last byte read by the host |
| vid_data | output | 8 | Byte placed on the video output bus |
| vid_valid | output | 1 | vid_data carries a fresh byte this cycle |
| thresh_irq | output | 1 | Word occupancy above threshold |
| overflow | output | 1 | Sticky dropped-write flag |
| flush_busy | output | 1 | Self-clearing flush status bit |

## Verification
Some properties are checked by assertions on every cycle. The fill count never exceeds 512. A flush strobe is always followed by the busy bit and an empty store. Overflow cannot drop except by a flush. A simultaneous push and pop leaves the count unchanged. The video port stays silent while the host owns the store, and an empty host read yields zero. Other behaviour can only be shown by the bench scenarios, with a queue model compared each cycle: byte ordering across many bytes, the exact word count at which the interrupt rises and falls for several thresholds, ignored pushes during a flush, and dropped bytes past 512 that never reappear.

// File: rtl/anc_fifo_pkg.sv
package anc_fifo_pkg;
    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } flush_st_e;
endpackage

// File: rtl/anc_fifo_ctrl.sv
module anc_fifo_ctrl
    import anc_fifo_pkg::*;
#(
    parameter int TW         = 8,
    parameter logic [TW-1:0] THRESH_RST = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_we,
    input  logic          thresh_we,
    input  logic [TW-1:0] thresh_val,
    input  logic          route_we,
    input  logic          route_sel,
    output logic          clear,
    output logic          flush_busy,
    output logic [TW-1:0] thresh_q,
    output logic          route_q
);
    flush_st_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_RUN:   st_nx = flush_we ? ST_FLUSH : ST_RUN;
            ST_FLUSH: st_nx = flush_we ? ST_FLUSH : ST_RUN;
            default:  st_nx = ST_RUN;
        endcase
    end

    always_comb begin
        clear      = (st == ST_FLUSH);
        flush_busy = (st == ST_FLUSH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thresh_q <= THRESH_RST;
            route_q  <= 1'b0;
        end else begin
            if (thresh_we) thresh_q <= thresh_val;
            if (route_we)  route_q  <= route_sel;
        end
    end

    // R6
    flush_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_we |=> flush_busy);
endmodule

// File: rtl/anc_fifo_store.sv
module anc_fifo_store #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          pop_ok,
    output logic          drop
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          push_ok;

    always_comb begin
        push_ok = push && !clear && (count != CW'(DEPTH));
        drop    = push && !clear && (count == CW'(DEPTH));
        pop_ok  = pop  && !clear && (count != '0);
        head    = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (clear) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));
    // R10
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !clear && count != '0 && count != CW'(DEPTH))
        |=> (count == $past(count)));
endmodule

// File: rtl/anc_data_fifo.sv
module anc_data_fifo #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    parameter int TW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_byte,
    input  logic          host_rd,
    input  logic          vid_pop,
    input  logic          thresh_we,
    input  logic [TW-1:0] thresh_val,
    input  logic          flush_we,
    input  logic          route_we,
    input  logic          route_sel,
    output logic [DW-1:0] host_data,
    output logic [DW-1:0] vid_data,
    output logic          vid_valid,
    output logic          thresh_irq,
    output logic          overflow,
    output logic          flush_busy
);
    logic          clear, route_q, pop_req, pop_ok, drop;
    logic [TW-1:0] thresh_q;
    logic [DW-1:0] head;
    logic [CW-1:0] count;

    anc_fifo_ctrl #(.TW(TW), .THRESH_RST(TW'(8'h80))) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush_we(flush_we),
        .thresh_we(thresh_we), .thresh_val(thresh_val),
        .route_we(route_we), .route_sel(route_sel),
        .clear(clear), .flush_busy(flush_busy),
        .thresh_q(thresh_q), .route_q(route_q)
    );

    assign pop_req = route_q ? host_rd : vid_pop;

    anc_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .push(wr_en), .din(wr_byte), .pop(pop_req),
        .head(head), .count(count), .pop_ok(pop_ok), .drop(drop)
    );

    assign thresh_irq = CW'(count >> 1) > CW'(thresh_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_data <= '0;
            vid_data  <= '0;
            vid_valid <= 1'b0;
            overflow  <= 1'b0;
        end else if (clear) begin
            host_data <= '0;
            vid_data  <= '0;
            vid_valid <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            vid_valid <= pop_ok && !route_q;
            if (pop_ok && !route_q) vid_data <= head;
            if (route_q && host_rd) host_data <= pop_ok ? head : '0;
            if (drop) overflow <= 1'b1;
        end
    end

    // R3
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear) |=> overflow);
    // R8
    host_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_q |=> !vid_valid);
    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q && host_rd && count == '0 && !clear) |=> (host_data == '0));
endmodule

// File: tb/sim_anc_data_fifo.sv
module sim_anc_data_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, host_rd = 0, vid_pop = 0, thresh_we = 0;
    logic       flush_we = 0, route_we = 0, route_sel = 0;
    logic [7:0] wr_byte = 0, thresh_val = 0;
    logic [7:0] host_data, vid_data;
    logic       vid_valid, thresh_irq, overflow, flush_busy;

    int errors = 0, checks = 0;

    // reference model state
    logic [7:0] q[$];
    int         m_thr = 128;
    bit         m_route = 0, m_busy = 0, m_ovf = 0, m_vv = 0, m_irq = 0;
    logic [7:0] m_hd = 0, m_vd = 0;

    always #5 clk = ~clk;

    anc_data_fifo u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
        .host_rd(host_rd), .vid_pop(vid_pop), .thresh_we(thresh_we),
        .thresh_val(thresh_val), .flush_we(flush_we), .route_we(route_we),
        .route_sel(route_sel), .host_data(host_data), .vid_data(vid_data),
        .vid_valid(vid_valid), .thresh_irq(thresh_irq), .overflow(overflow),
        .flush_busy(flush_busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit busy_now, route_now, pop, popreq;
        int n;
        logic [7:0] h;
        busy_now = m_busy;
        route_now = m_route;
        m_busy = flush_we;
        if (busy_now) begin
            q.delete();
            m_ovf = 0; m_hd = 0; m_vd = 0; m_vv = 0;
        end else begin
            n = q.size();
            h = (n > 0) ? q[0] : 8'h00;
            popreq = route_now ? host_rd : vid_pop;
            pop = popreq && (n > 0);
            m_vv = pop && !route_now;
            if (m_vv) m_vd = h;
            if (route_now && host_rd) m_hd = pop ? h : 8'h00;
            if (pop) void'(q.pop_front());
            if (wr_en) begin
                if (n < 512) q.push_back(wr_byte);
                else m_ovf = 1;
            end
        end
        if (thresh_we) m_thr = thresh_val;
        if (route_we) m_route = route_sel;
        m_irq = (q.size() / 2) > m_thr;
    endtask

    task automatic compare();
        chk("R8 host_data", host_data, m_hd);
        chk("R7 vid_data", vid_data, m_vd);
        chk("R7 vid_valid", vid_valid, m_vv);
        chk("R4 thresh_irq", thresh_irq, m_irq);
        chk("R3 overflow", overflow, m_ovf);
        chk("R6 flush_busy", flush_busy, m_busy);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #2;
        compare();
        wr_en = 0; host_rd = 0; vid_pop = 0; thresh_we = 0;
        flush_we = 0; route_we = 0;
    endtask

    task automatic push(input logic [7:0] b);
        wr_en = 1; wr_byte = b; tick();
    endtask

    task automatic set_thr(input logic [7:0] t);
        thresh_we = 1; thresh_val = t; tick();
    endtask

    task automatic set_route(input bit r);
        route_we = 1; route_sel = r; tick();
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #23 rst_n = 1;
        #1;
        // R1: reset state
        chk("R1 host_data", host_data, 0);
        chk("R1 vid_valid", vid_valid, 0);
        chk("R1 thresh_irq", thresh_irq, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 flush_busy", flush_busy, 0);
        @(negedge clk);
        tick();

        // R2 / R7: ordered drain onto the video bus, host_rd ignored
        for (int i = 0; i < 6; i++) push(8'hA0 + 8'(i));
        host_rd = 1; tick();
        for (int i = 0; i < 6; i++) begin
            vid_pop = 1; tick();
            chk("R2 order", vid_data, 8'hA0 + i);
        end
        // R9: pop on empty store
        vid_pop = 1; tick();
        chk("R9 empty vid_valid", vid_valid, 0);

        // R5 / R4: threshold 2 words
        set_thr(8'd2);
        for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
        chk("R4 five bytes below", thresh_irq, 0);
        push(8'h15);
        chk("R4 six bytes above", thresh_irq, 1);
        vid_pop = 1; tick();
        chk("R4 falls after pop", thresh_irq, 0);
        set_thr(8'd1);
        chk("R5 new threshold", thresh_irq, 1);

        // R8: host routing, vid_pop ignored
        set_route(1);
        vid_pop = 1; tick();
        chk("R8 vid silent", vid_valid, 0);
        for (int i = 0; i < 5; i++) begin
            host_rd = 1; tick();
            chk("R8 host order", host_data, 8'h11 + i);
        end
        host_rd = 1; tick();
        chk("R9 empty host read", host_data, 0);

        // R10: simultaneous push and pop
        push(8'h55); push(8'h66);
        wr_en = 1; wr_byte = 8'h77; host_rd = 1; tick();
        chk("R10 popped head", host_data, 8'h55);
        host_rd = 1; tick();
        chk("R10 next", host_data, 8'h66);
        host_rd = 1; tick();
        chk("R10 pushed byte kept", host_data, 8'h77);

        // R3 / R4: fill past 512 with maximum threshold
        set_thr(8'hFF);
        for (int i = 0; i < 520; i++) begin
            push(8'(i));
            if (i == 510) chk("R4 511 bytes not above 255", thresh_irq, 0);
        end
        chk("R4 256 words above 255", thresh_irq, 1);
        chk("R3 overflow set", overflow, 1);
        host_rd = 1; tick();
        chk("R3 overflow sticky", overflow, 1);
        for (int i = 1; i < 512; i++) begin
            host_rd = 1; tick();
        end
        chk("R3 last kept byte", host_data, 8'hFF);
        host_rd = 1; tick();
        chk("R3 dropped bytes gone", host_data, 0);

        // R6: flush, with push and pop during the clearing cycle
        push(8'h21); push(8'h22); push(8'h23);
        host_rd = 1; tick();
        flush_we = 1; tick();
        chk("R6 busy after write", flush_busy, 1);
        wr_en = 1; wr_byte = 8'h99; host_rd = 1; tick();
        chk("R6 host_data cleared", host_data, 0);
        chk("R6 busy self-clears", flush_busy, 0);
        host_rd = 1; tick();
        chk("R6 store empty", host_data, 0);
        // back-to-back flush strobes
        flush_we = 1; tick();
        flush_we = 1; tick();
        chk("R6 stays busy", flush_busy, 1);
        tick();
        tick();
        chk("R6 idle", flush_busy, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule